// File: doc/BRIEF.md
# SPI Framed Register Slave

This block is an SPI slave (clock polarity and phase both zero, most significant bit first) that gives a host controller byte-wide read and write access to a bank of on-chip registers. Every transaction is one chip-select window. The host sends an address byte and then a command byte. The command byte holds a direction flag and a payload length of up to 127 bytes. A write window carries the payload from the host. A read window carries it from the slave. In both directions the side that supplies the payload closes it with a checksum byte. The checksum is the inverted 8-bit sum of the payload bytes.

While the host clocks out the address and command bytes, the slave answers with a status byte. The status byte shows whether the last write window failed its checksum and whether the slave is still busy storing the last good write. The host can therefore find out about integrity problems and poll for readiness within ordinary transactions.

Write payloads are held in a staging buffer. They reach the registers only after the checksum matches. The buffer is then drained into the register port at one byte per system clock. On the register side there is a plain synchronous port. Addresses advance by one per byte unless bit 7 of the base address is set. In that case every byte uses the same address, which suits a FIFO-like register.

SPI inputs are sampled with the system clock through two-flop synchronizers. The SPI clock must therefore be well below the system clock.

Top module: `sfr_spi_regslave`

## Requirements
- R1: A falling chip select starts a new frame and a rising chip select ends or abandons it. After reset, MISO is low and the first status byte of a frame is 0x00.
- R2: During the address byte and during the command byte, the slave shifts out the status byte. Bit 0 is the previous write checksum error, bit 1 is busy, and bits 7:2 are zero.
- R3: Command bit 7 = 1 selects a write and bits 6:0 give the payload length. The slave shifts out 0x00 during the write payload and during the checksum byte. Payload byte i is written to base+i, and only after a matching checksum.
- R4: The checksum is the bitwise inverse of the payload sum modulo 256. A write whose checksum byte differs from it writes no register and sets the error bit.
- R5: A write frame whose checksum matches clears the error bit.
- R6: If chip select rises after a write command byte but before the checksum byte has completed, the payload is discarded, no register is written and the error bit is set.
- R7: Command bit 7 = 0 selects a read. The slave returns the bytes at base+0 … base+len-1 in the following byte slots, then the inverted payload sum.
- R8: When bit 7 of the address byte is set, every payload byte of a read or write uses the base address unchanged.
- R9: A length of zero is legal. A zero-length write with checksum 0xFF succeeds and writes nothing. A zero-length read returns 0xFF as its checksum.
- R10: A matched write is stored with one register write per clock on consecutive cycles, and busy is 1 for that whole time. A frame that begins while busy returns busy=1 in its first status byte, and its command is ignored.
- R11: `reg_re` is a single-cycle pulse, one per read payload byte. `reg_rdata` is taken in the cycle after the pulse. `reg_we` and `reg_re` are never high together.
- R12: A read frame does not change the error bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 8 | Register address |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_re` |

## Verification
Each MISO byte is prepared about three system clocks after the last SCK edge of the byte before it: two synchronizer stages plus one register. The next byte is loaded on the following falling edge. The bench holds each SCK phase for eight clocks and reads MISO at the instant it raises SCK, so every expected byte is settled and is compared in its own slot. A register read is answered by the bench's register model one clock after the strobe. The commit burst starts about three clocks after the checksum byte's last rising edge. Write counts, run lengths and strobe counts are therefore checked only after a gap long enough for a full 127-byte burst. The busy probe frame is deliberately started four clocks after chip select rises, inside that burst.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // status byte bit positions
  localparam int STAT_ERR_BIT  = 0;
  localparam int STAT_BUSY_BIT = 1;
  // command byte direction flag position
  localparam int CMD_WR_BIT    = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WPAY,
    ST_WCHK,
    ST_RPAY,
    ST_RCHK,
    ST_COMMIT,
    ST_DONE
  } frame_state_e;
endpackage

// File: rtl/sfr_sync_shift.sv
module sfr_sync_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  input  logic [DW-1:0] tx_next,
  output logic          cs_act,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = $clog2(DW);

  logic [2:0]    sck_q;
  logic [1:0]    cs_q, mosi_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d, tx_q, tx_d, byte_q, byte_d;
  logic          pend_q, pend_d, done_q, done_d;
  logic          sck_rise, sck_fall;

  assign sck_rise  = sck_q[1] & ~sck_q[2];
  assign sck_fall  = ~sck_q[1] & sck_q[2];
  assign cs_act    = ~cs_q[1];
  assign miso      = tx_q[DW-1];
  assign byte_done = done_q;
  assign rx_byte   = byte_q;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    byte_d = byte_q;
    pend_d = pend_q;
    done_d = 1'b0;
    if (!cs_act) begin
      cnt_d  = '0;
      pend_d = 1'b0;
      tx_d   = tx_next;
    end else begin
      if (sck_rise) begin
        rx_d = {rx_q[DW-2:0], mosi_q[1]};
        if (cnt_q == CW'(DW-1)) begin
          cnt_d  = '0;
          done_d = 1'b1;
          pend_d = 1'b1;
          byte_d = {rx_q[DW-2:0], mosi_q[1]};
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (sck_fall) begin
        if (pend_q) begin
          tx_d   = tx_next;
          pend_d = 1'b0;
        end else begin
          tx_d = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      byte_q <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      byte_q <= byte_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_act) && !$past(sck_fall)) |-> $stable(tx_q));
endmodule

// File: rtl/sfr_wbuf.sv
module sfr_wbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 127
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/sfr_frame.sv
module sfr_frame
  import sfr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LW        = 7,
  parameter int FIXED_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] tx_next,
  output logic [DW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata,
  output logic          buf_we,
  output logic [LW-1:0] buf_idx,
  input  logic [DW-1:0] buf_rdata
);
  frame_state_e  state_q, state_d;
  logic [DW-1:0] base_q, base_d, sum_q, sum_d, txq_q, txq_d;
  logic [LW-1:0] len_q, len_d, idx_q, idx_d;
  logic          err_q, err_d, re_q, re_d, rdp_q;
  logic          busy;
  logic [DW-1:0] status;

  assign busy = (state_q == ST_COMMIT);
  always_comb begin
    status                = '0;
    status[STAT_ERR_BIT]  = err_q;
    status[STAT_BUSY_BIT] = busy;
  end

  assign tx_next   = (state_q inside {ST_WPAY, ST_WCHK, ST_RPAY, ST_RCHK}) ? txq_q : status;
  assign reg_re    = re_q;
  assign reg_we    = busy;
  assign reg_wdata = buf_rdata;
  assign reg_addr  = base_q + (base_q[FIXED_BIT] ? '0 : {{(DW-LW){1'b0}}, idx_q});
  assign buf_idx   = idx_q;

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    sum_d   = sum_q;
    txq_d   = txq_q;
    len_d   = len_q;
    idx_d   = idx_q;
    err_d   = err_q;
    re_d    = 1'b0;
    buf_we  = 1'b0;
    if (rdp_q) begin
      txq_d = reg_rdata;
      sum_d = sum_q + reg_rdata;
      idx_d = idx_q + 1'b1;
    end
    unique case (state_q)
      ST_IDLE: if (cs_act) state_d = ST_ADDR;
      ST_ADDR: begin
        if (!cs_act) state_d = ST_IDLE;
        else if (byte_done) begin
          base_d  = rx_byte;
          state_d = ST_CMD;
        end
      end
      ST_CMD: begin
        if (!cs_act) state_d = ST_IDLE;
        else if (byte_done) begin
          len_d = rx_byte[LW-1:0];
          sum_d = '0;
          idx_d = '0;
          if (rx_byte[CMD_WR_BIT]) begin
            txq_d   = '0;
            state_d = (rx_byte[LW-1:0] == '0) ? ST_WCHK : ST_WPAY;
          end else if (rx_byte[LW-1:0] == '0) begin
            txq_d   = '1;
            state_d = ST_RCHK;
          end else begin
            re_d    = 1'b1;
            state_d = ST_RPAY;
          end
        end
      end
      ST_WPAY: begin
        if (!cs_act) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (byte_done) begin
          buf_we = 1'b1;
          sum_d  = sum_q + rx_byte;
          idx_d  = idx_q + 1'b1;
          if (idx_q + 1'b1 == len_q) state_d = ST_WCHK;
        end
      end
      ST_WCHK: begin
        if (!cs_act) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (byte_done) begin
          idx_d = '0;
          if (rx_byte == ~sum_q) begin
            err_d   = 1'b0;
            state_d = (len_q == '0) ? ST_DONE : ST_COMMIT;
          end else begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_RPAY: begin
        if (!cs_act) state_d = ST_IDLE;
        else if (byte_done) begin
          if (idx_q == len_q) begin
            txq_d   = ~sum_q;
            state_d = ST_RCHK;
          end else begin
            re_d = 1'b1;
          end
        end
      end
      ST_RCHK: begin
        if (!cs_act) state_d = ST_IDLE;
        else if (byte_done) state_d = ST_DONE;
      end
      ST_COMMIT: begin
        idx_d = idx_q + 1'b1;
        if (idx_q + 1'b1 == len_q) state_d = ST_DONE;
      end
      ST_DONE: if (!cs_act) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      sum_q   <= '0;
      txq_q   <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
      re_q    <= 1'b0;
      rdp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      sum_q   <= sum_d;
      txq_q   <= txq_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
      re_q    <= re_d;
      rdp_q   <= re_q;
    end
  end

  // R11
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  // R11
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  // R10
  commit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < len_q));
  // R6
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WPAY && !cs_act) |=> err_q);
  // R3
  commit_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_we) |-> !err_q);
endmodule

// File: rtl/sfr_spi_regslave.sv
module sfr_spi_regslave #(
  parameter int DW        = 8,
  parameter int LW        = 7,
  parameter int FIXED_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [DW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);
  localparam int DEPTH = (2 ** LW) - 1;

  logic [1:0]    rst_sq;
  logic          rst_ni;
  logic          cs_act, byte_done, buf_we;
  logic [DW-1:0] rx_byte, tx_next, buf_rdata;
  logic [LW-1:0] buf_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  sfr_sync_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_ni), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_next(tx_next), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(spi_miso)
  );

  sfr_wbuf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(buf_we), .idx(buf_idx), .wdata(rx_byte), .rdata(buf_rdata)
  );

  sfr_frame #(.DW(DW), .LW(LW), .FIXED_BIT(FIXED_BIT)) u_frame (
    .clk(clk), .rst_n(rst_ni), .cs_act(cs_act), .byte_done(byte_done),
    .rx_byte(rx_byte), .tx_next(tx_next), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_rdata(buf_rdata)
  );
endmodule

// File: tb/sim_sfr_spi_regslave.sv
`timescale 1ns/1ps
module sim_sfr_spi_regslave;
  localparam int HP  = 8;
  localparam int GAP = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  int vectors = 0, fails = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  act_q[$];
  string       tag_q[$];
  logic [7:0]  mem [256];
  logic [7:0]  ref_mem [256];
  logic [7:0]  pay [127];
  logic        err_m = 1'b0;
  int we_cnt = 0, re_cnt = 0, run = 0, last_run = 0;

  always #2.5 clk = ~clk;

  sfr_spi_regslave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  // register bank seen by the block
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (reg_we) mem[reg_addr] <= reg_wdata;
      if (reg_re) reg_rdata <= mem[reg_addr];
      if (reg_we) we_cnt <= we_cnt + 1;
      if (reg_re) re_cnt <= re_cnt + 1;
      if (reg_we) run <= run + 1;
      else if (run != 0) begin
        last_run <= run;
        run <= 0;
      end
    end
  end

  // monitor: pairs each received MISO byte with the expected one
  logic [15:0] m_e;
  logic [7:0]  m_a;
  string       m_t;
  always @(negedge clk) begin
    if (act_q.size() != 0 && exp_q.size() != 0) begin
      m_a = act_q.pop_front();
      m_e = exp_q.pop_front();
      m_t = tag_q.pop_front();
      vectors++;
      if ((m_a & m_e[15:8]) != (m_e[7:0] & m_e[15:8])) begin
        fails++;
        $display("FAIL %s: miso byte %h, expected %h (mask %h)", m_t, m_a, m_e[7:0], m_e[15:8]);
      end
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] mo, input logic [7:0] ev,
                      input logic [7:0] em, input string tag);
    logic [7:0] mi;
    exp_q.push_back({em, ev});
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      mi[i] = miso;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    act_q.push_back(mi);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic close_frame(input int gap);
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  // write frame; cut >= 0 raises chip select after that many payload bytes
  task automatic wr_frame(input logic [7:0] addr, input int len, input bit bad,
                          input int cut, input int gap);
    logic [7:0] st, sum;
    int n;
    st  = {6'b0, 1'b0, err_m};
    sum = 8'h00;
    n   = (cut >= 0) ? cut : len;
    open_frame();
    xfer(addr, st, 8'hFF, "R2 status in address slot");
    xfer({1'b1, 7'(len)}, st, 8'hFF, "R2 status in command slot");
    for (int i = 0; i < n; i++) begin
      xfer(pay[i], 8'h00, 8'hFF, "R3 zeros during write payload");
      sum = sum + pay[i];
    end
    if (cut < 0) xfer((~sum) ^ (bad ? 8'h01 : 8'h00), 8'h00, 8'hFF, "R3 zeros in checksum slot");
    close_frame(gap);
    if (cut >= 0 || bad) err_m = 1'b1;
    else begin
      err_m = 1'b0;
      for (int i = 0; i < len; i++) ref_mem[addr[7] ? addr : 8'(addr + i)] = pay[i];
    end
  endtask

  task automatic rd_frame(input logic [7:0] addr, input int len);
    logic [7:0] st, sum, v;
    int re0;
    string t;
    st  = {6'b0, 1'b0, err_m};
    sum = 8'h00;
    re0 = re_cnt;
    t   = addr[7] ? "R8 fixed-address read payload" : "R7 read payload";
    open_frame();
    xfer(addr, st, 8'hFF, "R2 status in address slot (read)");
    xfer({1'b0, 7'(len)}, st, 8'hFF, "R12 status in command slot (read)");
    for (int i = 0; i < len; i++) begin
      v = ref_mem[addr[7] ? addr : 8'(addr + i)];
      sum = sum + v;
      xfer(8'h00, v, 8'hFF, t);
    end
    xfer(8'h00, ~sum, 8'hFF, (len == 0) ? "R9 zero-length read checksum" : "R7 read checksum");
    close_frame(20);
    check(re_cnt - re0, len, "R11 one read strobe per payload byte");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog: run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int we0;
    for (int i = 0; i < 256; i++) ref_mem[i] = init_val(i);
    for (int i = 0; i < 127; i++) pay[i] = 8'(i * 13 + 5);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(miso, 0, "R1 miso low after reset");
    check(reg_we, 0, "R1 no write strobe after reset");
    check(reg_re, 0, "R1 no read strobe after reset");

    // R1 R2 R7 first frame after reset
    rd_frame(8'h20, 3);

    // R3 good write then readback
    we0 = we_cnt;
    wr_frame(8'h10, 5, 1'b0, -1, GAP);
    check(we_cnt - we0, 5, "R3 register writes after matching checksum");
    rd_frame(8'h10, 5);

    // R4 bad checksum, R12 reads keep error bit
    we0 = we_cnt;
    wr_frame(8'h30, 2, 1'b1, -1, GAP);
    check(we_cnt - we0, 0, "R4 no register write on checksum mismatch");
    rd_frame(8'h30, 2);
    rd_frame(8'h31, 1);

    // R9 zero length, R5 clear of error
    we0 = we_cnt;
    wr_frame(8'h50, 0, 1'b0, -1, GAP);
    check(we_cnt - we0, 0, "R9 zero-length write touches no register");
    rd_frame(8'h50, 0);

    // R6 abandoned write
    we0 = we_cnt;
    wr_frame(8'h40, 4, 1'b0, 2, GAP);
    check(we_cnt - we0, 0, "R6 abandoned write touches no register");
    rd_frame(8'h40, 4);

    // R5 good write clears error
    wr_frame(8'h60, 2, 1'b0, -1, GAP);
    rd_frame(8'h60, 2);

    // R8 fixed address
    we0 = we_cnt;
    wr_frame(8'h85, 3, 1'b0, -1, GAP);
    check(we_cnt - we0, 3, "R8 fixed-address write count");
    check(last_run, 3, "R10 commit burst length for three bytes");
    rd_frame(8'h85, 3);

    // R10 full-length write, then a frame during commit
    we0 = we_cnt;
    wr_frame(8'h00, 127, 1'b0, -1, 4);
    open_frame();
    xfer(8'h10, 8'h02, 8'hFF, "R10 busy flag at frame start");
    xfer(8'h81, 8'h00, 8'h00, "R10 ignored command");
    xfer(8'hAA, 8'h00, 8'h00, "R10 ignored payload");
    xfer(8'h55, 8'h00, 8'h00, "R10 ignored checksum");
    close_frame(GAP);
    check(we_cnt - we0, 127, "R10 only the committed bytes are written");
    check(last_run, 127, "R10 commit writes on consecutive cycles");
    rd_frame(8'h10, 1);
    rd_frame(8'h00, 127);

    repeat (20) @(negedge clk);
    check(exp_q.size(), 0, "R1 every expected byte observed");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule